// File: doc/BRIEF.md
# Timer Command Strobe Bridge

This block carries one-shot commands from a register bus into a timer that runs on its own unrelated clock. Software writes an 8-bit control word. Each bit that is set is a request, and the bits clear themselves. The requests are capture of the counter into one of two capture registers, a counter restart, an immediate load of the double-buffered period and compare values, a load of those values deferred to the end of the running cycle, and a disable deferred to the end of the running cycle. Accepted commands cross into the timer domain over a toggle handshake. Two ready flags report on the bus side whether a new request can be taken.

The timer is modelled as a counter that counts up to its active period and then wraps. It raises a one-clock cycle-end pulse on the last count. It also holds two capture registers and an active period/compare pair that are loaded from bus-side buffer inputs. The bus edge has no valid/ready flow control of its own. A write made while the matching ready flag is low is not stalled and is not queued. It is simply lost, and the ready flag is the only back-pressure signal that software sees.

Top module: `tmr_cmd_bridge`

## Requirements
- R1: After reset, cmd_ready and en_ready are 1, the timer is stopped, and tmr_count, cap_a, cap_b, act_period and act_cmp are all 0.
- R2: The control word uses these bit positions: bit 0 = end-of-cycle load, bit 1 = immediate load, bit 2 = restart, bit 3 = capture A, bit 4 = capture B, bit 7 = end-of-cycle disable. Bits 5 and 6 have no effect. A write with any of bits 4..0 set while cmd_ready is 1 is accepted, and cmd_ready is 0 on the next bus clock. cmd_ready returns to 1 only after the timer side has acknowledged the command.
- R3: A write of bits 4..0 made while cmd_ready is 0 is dropped and has no effect.
- R4: Capture A (or B) copies the counter value of the timer clock in which the command executes into cap_a (or cap_b). When both bits are set in one write, both captures happen in the same timer clock and hold equal values.
- R5: A restart sets the counter to 0 in the timer clock in which it executes.
- R6: An immediate load copies buf_period and buf_cmp, as sampled when the write was accepted, into act_period and act_cmp.
- R7: An end-of-cycle load on a running timer waits for the next cycle-end pulse, and cmd_ready stays 0 until the load is done. If the timer is stopped, the load happens at once.
- R8: While enabled, the counter increments on every timer clock. When it equals act_period, tmr_cycle_end is 1 and the counter returns to 0 on the next clock.
- R9: A write on en_we sets the timer enable to en_wdata. en_ready is 0 from the next bus clock until the new value has been applied in the timer domain.
- R10: An end-of-cycle disable on a running timer stops it at the next cycle-end pulse, which leaves the counter at 0. en_ready stays 0 until the timer has stopped.
- R11: A disable request written while en_ready is 0, or in the same bus clock as an en_we write, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| bus_rst_n | input | 1 | Active-low asynchronous reset, bus domain |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word write data |
| en_we | input | 1 | Enable write strobe |
| en_wdata | input | 1 | Enable value to write |
| buf_period | input | CW | Buffered period value |
| buf_cmp | input | CW | Buffered compare value |
| cmd_ready | output | 1 | High when a command write will be accepted |
| en_ready | output | 1 | High when an enable or disable write will be accepted |
| tmr_clk | input | 1 | Timer clock, asynchronous to bus_clk |
| tmr_rst_n | input | 1 | Active-low asynchronous reset, timer domain |
| tmr_count | output | CW | Timer counter |
| tmr_cycle_end | output | 1 | One-clock pulse on the last count of a cycle |
| tmr_enabled | output | 1 | Timer running |
| cap_a | output | CW | Capture register A |
| cap_b | output | CW | Capture register B |
| act_period | output | CW | Active period |
| act_cmp | output | CW | Active compare value |

## Verification
Single-bit commands are issued both on a stopped timer and on a running one. This separates the deferred end-of-cycle paths from the immediate ones, which take effect without waiting for a cycle end. Command writes made during a pending end-of-cycle load, and disable requests made during an enable handshake, show whether busy periods really drop writes. A command that sets both capture bits checks that the two captures land in the same timer clock. Seeded random sequences of mixed bits and gaps test each accepted load against the buffer values held at acceptance. Throughout the run, a monitor compares every capture with the counter value of the preceding timer clock.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  localparam int B_LOAD_EOC = 0;
  localparam int B_LOAD_NOW = 1;
  localparam int B_RESTART  = 2;
  localparam int B_CAP_A    = 3;
  localparam int B_CAP_B    = 4;
  localparam int B_DIS_EOC  = 7;
  localparam int NCMD       = 5;

  // field order follows control bits 4..0
  typedef struct packed {
    logic cap_b;
    logic cap_a;
    logic restart;
    logic load_now;
    logic load_eoc;
  } cmd_t;
endpackage

// File: rtl/tcb_sync2.sv
module tcb_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/tcb_xing.sv
module tcb_xing #(
  parameter int W = 8
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic         src_fire,
  input  logic [W-1:0] src_data,
  output logic         src_busy,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic         dst_new,
  output logic [W-1:0] dst_data,
  input  logic         dst_done
);
  logic         req_tgl, ack_tgl;
  logic         req_s, ack_s, seen;
  logic [W-1:0] hold;

  // source side: payload is frozen while the request is outstanding
  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      req_tgl <= 1'b0;
      hold    <= '0;
    end else if (src_fire && !src_busy) begin
      req_tgl <= ~req_tgl;
      hold    <= src_data;
    end
  end

  assign src_busy = req_tgl ^ ack_s;

  tcb_sync2 #(.W(1)) u_req_sync (
    .clk(dst_clk), .rst_n(dst_rst_n), .d(req_tgl), .q(req_s)
  );

  // destination side
  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      seen    <= 1'b0;
      ack_tgl <= 1'b0;
    end else begin
      seen <= req_s;
      if (dst_done) ack_tgl <= ~ack_tgl;
    end
  end

  assign dst_new  = req_s ^ seen;
  assign dst_data = hold;

  tcb_sync2 #(.W(1)) u_ack_sync (
    .clk(src_clk), .rst_n(src_rst_n), .d(ack_tgl), .q(ack_s)
  );
endmodule

// File: rtl/tcb_timer_core.sv
module tcb_timer_core
  import tcb_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_new,
  input  cmd_t          cmd,
  input  logic [CW-1:0] ld_per,
  input  logic [CW-1:0] ld_cmp,
  output logic          cmd_done,
  input  logic          en_new,
  input  logic          en_dis,
  input  logic          en_val,
  output logic          en_done,
  output logic [CW-1:0] count,
  output logic          cycle_end,
  output logic          enabled,
  output logic [CW-1:0] cap_a,
  output logic [CW-1:0] cap_b,
  output logic [CW-1:0] act_per,
  output logic [CW-1:0] act_cmp
);
  logic eoc_pend, dis_pend;
  logic restart, eoc_fire, dis_fire, load;

  always_comb begin
    cycle_end = enabled && (count == act_per);
    restart   = cmd_new && cmd.restart;
    eoc_fire  = eoc_pend && (cycle_end || !enabled);
    dis_fire  = dis_pend && (cycle_end || !enabled);
    load      = (cmd_new && cmd.load_now) ||
                (cmd_new && cmd.load_eoc && !enabled) || eoc_fire;
  end

  assign cmd_done = (cmd_new && !(cmd.load_eoc && enabled)) || eoc_fire;
  assign en_done  = (en_new && !(en_dis && enabled)) || dis_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      cap_a    <= '0;
      cap_b    <= '0;
      act_per  <= '0;
      act_cmp  <= '0;
      enabled  <= 1'b0;
      eoc_pend <= 1'b0;
      dis_pend <= 1'b0;
    end else begin
      if (restart || cycle_end) count <= '0;
      else if (enabled)         count <= count + 1'b1;

      if (cmd_new && cmd.cap_a) cap_a <= count;
      if (cmd_new && cmd.cap_b) cap_b <= count;

      if (load) begin
        act_per <= ld_per;
        act_cmp <= ld_cmp;
      end

      if (cmd_new && cmd.load_eoc && enabled) eoc_pend <= 1'b1;
      else if (eoc_fire)                      eoc_pend <= 1'b0;

      if (en_new && !en_dis) enabled <= en_val;
      else if (dis_fire)     enabled <= 1'b0;

      if (en_new && en_dis && enabled) dis_pend <= 1'b1;
      else if (dis_fire)               dis_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_cmd_bridge.sv
module tmr_cmd_bridge
  import tcb_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          bus_clk,
  input  logic          bus_rst_n,
  input  logic          ctrl_we,
  input  logic [7:0]    ctrl_wdata,
  input  logic          en_we,
  input  logic          en_wdata,
  input  logic [CW-1:0] buf_period,
  input  logic [CW-1:0] buf_cmp,
  output logic          cmd_ready,
  output logic          en_ready,
  input  logic          tmr_clk,
  input  logic          tmr_rst_n,
  output logic [CW-1:0] tmr_count,
  output logic          tmr_cycle_end,
  output logic          tmr_enabled,
  output logic [CW-1:0] cap_a,
  output logic [CW-1:0] cap_b,
  output logic [CW-1:0] act_period,
  output logic [CW-1:0] act_cmp
);
  localparam int CMD_W = NCMD + 2 * CW;
  localparam int EN_W  = 2;

  logic             cmd_busy, en_busy;
  logic             cmd_fire, en_fire;
  logic [CMD_W-1:0] cmd_payload, cmd_x;
  logic [EN_W-1:0]  en_payload, en_x;
  logic             cmd_new, cmd_done, en_new, en_done;
  cmd_t             cmd_bits;
  logic             unused_ctrl_bits;

  assign unused_ctrl_bits = ^ctrl_wdata[6:5];

  assign cmd_fire    = ctrl_we && (|ctrl_wdata[NCMD-1:0]);
  assign cmd_payload = {buf_period, buf_cmp, ctrl_wdata[NCMD-1:0]};
  assign en_fire     = en_we || (ctrl_we && ctrl_wdata[B_DIS_EOC]);
  assign en_payload  = {~en_we, en_wdata};

  assign cmd_ready = ~cmd_busy;
  assign en_ready  = ~en_busy;

  tcb_xing #(.W(CMD_W)) u_cmd_xing (
    .src_clk(bus_clk), .src_rst_n(bus_rst_n),
    .src_fire(cmd_fire), .src_data(cmd_payload), .src_busy(cmd_busy),
    .dst_clk(tmr_clk), .dst_rst_n(tmr_rst_n),
    .dst_new(cmd_new), .dst_data(cmd_x), .dst_done(cmd_done)
  );

  tcb_xing #(.W(EN_W)) u_en_xing (
    .src_clk(bus_clk), .src_rst_n(bus_rst_n),
    .src_fire(en_fire), .src_data(en_payload), .src_busy(en_busy),
    .dst_clk(tmr_clk), .dst_rst_n(tmr_rst_n),
    .dst_new(en_new), .dst_data(en_x), .dst_done(en_done)
  );

  assign cmd_bits = cmd_t'(cmd_x[NCMD-1:0]);

  tcb_timer_core #(.CW(CW)) u_core (
    .clk(tmr_clk), .rst_n(tmr_rst_n),
    .cmd_new(cmd_new), .cmd(cmd_bits),
    .ld_per(cmd_x[CMD_W-1 -: CW]), .ld_cmp(cmd_x[NCMD +: CW]),
    .cmd_done(cmd_done),
    .en_new(en_new), .en_dis(en_x[1]), .en_val(en_x[0]), .en_done(en_done),
    .count(tmr_count), .cycle_end(tmr_cycle_end), .enabled(tmr_enabled),
    .cap_a(cap_a), .cap_b(cap_b), .act_per(act_period), .act_cmp(act_cmp)
  );
endmodule

// File: rtl/tcb_bridge_chk.sv
module tcb_bridge_chk #(
  parameter int CW = 16
) (
  input logic          bus_clk,
  input logic          bus_rst_n,
  input logic          tmr_clk,
  input logic          tmr_rst_n,
  input logic          ctrl_we,
  input logic [4:0]    cmd_bits,
  input logic          dis_bit,
  input logic          en_we,
  input logic          cmd_ready,
  input logic          en_ready,
  input logic [CW-1:0] tmr_count,
  input logic          tmr_cycle_end,
  input logic [CW-1:0] cap_a,
  input logic [CW-1:0] cap_b
);
  // R2
  cmd_busy_after_accept_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (ctrl_we && cmd_ready && (|cmd_bits)) |=> !cmd_ready);

  // R9
  en_busy_after_write_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (en_we && en_ready) |=> !en_ready);

  // R10
  dis_busy_after_accept_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (ctrl_we && dis_bit && en_ready) |=> !en_ready);

  // R8
  wrap_after_end_chk: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
    tmr_cycle_end |=> (tmr_count == '0));

  // R4
  cap_a_source_chk: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
    !$stable(cap_a) |-> (cap_a == $past(tmr_count)));

  // R4
  cap_b_source_chk: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
    !$stable(cap_b) |-> (cap_b == $past(tmr_count)));
endmodule

bind tmr_cmd_bridge tcb_bridge_chk #(.CW(CW)) u_chk (
  .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
  .tmr_clk(tmr_clk), .tmr_rst_n(tmr_rst_n),
  .ctrl_we(ctrl_we), .cmd_bits(ctrl_wdata[4:0]), .dis_bit(ctrl_wdata[7]),
  .en_we(en_we), .cmd_ready(cmd_ready), .en_ready(en_ready),
  .tmr_count(tmr_count), .tmr_cycle_end(tmr_cycle_end),
  .cap_a(cap_a), .cap_b(cap_b)
);

// File: tb/tb_tmr_cmd_bridge.sv
module tb_tmr_cmd_bridge;
  localparam int CW = 16;

  logic          bus_clk = 1'b0, tmr_clk = 1'b0;
  logic          bus_rst_n = 1'b0, tmr_rst_n = 1'b0;
  logic          ctrl_we = 1'b0, en_we = 1'b0, en_wdata = 1'b0;
  logic [7:0]    ctrl_wdata = '0;
  logic [CW-1:0] buf_period = '0, buf_cmp = '0;
  logic          cmd_ready, en_ready, tmr_cycle_end, tmr_enabled;
  logic [CW-1:0] tmr_count, cap_a, cap_b, act_period, act_cmp;

  int n_cmp = 0, n_bad = 0;
  bit ended = 0;

  always #10 bus_clk = ~bus_clk;
  always #7  tmr_clk = ~tmr_clk;

  tmr_cmd_bridge #(.CW(CW)) dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] c,
                                                input logic [CW-1:0] per);
    return (c == per) ? '0 : c + 1'b1;
  endfunction

  function automatic bit is_immediate_load(input logic [7:0] d);
    return d[1] && !d[0];
  endfunction

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // capture monitor: a capture holds the count of the previous timer clock
  logic [CW-1:0] last_cnt = '0, last_a = '0, last_b = '0;
  always @(negedge tmr_clk) begin
    if (tmr_rst_n) begin
      if (cap_a != last_a) chk(cap_a == last_cnt, "R4", "cap_a source", cap_a, last_cnt);
      if (cap_b != last_b) chk(cap_b == last_cnt, "R4", "cap_b source", cap_b, last_cnt);
    end
    last_a   = cap_a;
    last_b   = cap_b;
    last_cnt = tmr_count;
  end

  task automatic wr_ctrl(input logic [7:0] d);
    @(negedge bus_clk);
    ctrl_we = 1'b1; ctrl_wdata = d;
    @(negedge bus_clk);
    ctrl_we = 1'b0; ctrl_wdata = '0;
  endtask

  task automatic wr_en(input logic v);
    @(negedge bus_clk);
    en_we = 1'b1; en_wdata = v;
    @(negedge bus_clk);
    en_we = 1'b0;
  endtask

  task automatic wait_cmd(input int lim, input string req);
    int n = 0;
    while (!cmd_ready && n < lim) begin @(negedge bus_clk); n++; end
    if (!cmd_ready) chk(1'b0, req, "cmd_ready timeout", 0, 1);
  endtask

  task automatic wait_en(input int lim, input string req);
    int n = 0;
    while (!en_ready && n < lim) begin @(negedge bus_clk); n++; end
    if (!en_ready) chk(1'b0, req, "en_ready timeout", 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge bus_clk);
    chk(1'b0, "WD", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [CW-1:0] prev, keep, exp_p;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge bus_clk);
    bus_rst_n = 1'b1; tmr_rst_n = 1'b1;
    repeat (2) @(negedge bus_clk);

    // R1 reset state
    chk(cmd_ready && en_ready, "R1", "ready flags", {cmd_ready, en_ready}, 3);
    chk(!tmr_enabled && tmr_count == 0, "R1", "timer idle", tmr_count, 0);
    chk(cap_a == 0 && cap_b == 0, "R1", "captures", cap_a | cap_b, 0);
    chk(act_period == 0 && act_cmp == 0, "R1", "active values", act_period, 0);

    // R6/R2 immediate load on stopped timer
    buf_period = 9; buf_cmp = 4;
    wr_ctrl(8'h02);
    chk(!cmd_ready, "R2", "busy after accept", cmd_ready, 0);
    wait_cmd(50, "R6");
    chk(act_period == 9, "R6", "period loaded", act_period, 9);
    chk(act_cmp == 4, "R6", "compare loaded", act_cmp, 4);

    // R9 enable
    wr_en(1'b1);
    chk(!en_ready, "R9", "en busy", en_ready, 0);
    wait_en(50, "R9");
    chk(tmr_enabled, "R9", "timer running", tmr_enabled, 1);

    // R8 count sequence
    @(negedge tmr_clk);
    prev = tmr_count;
    for (int i = 0; i < 30; i++) begin
      @(negedge tmr_clk);
      chk(tmr_count == next_count(prev, act_period), "R8", "count step",
          tmr_count, next_count(prev, act_period));
      if (tmr_cycle_end) chk(tmr_count == act_period, "R8", "end pulse at period", tmr_count, act_period);
      prev = tmr_count;
    end

    // longer period, immediate load while running (R6)
    buf_period = 1000; buf_cmp = 10;
    wr_ctrl(8'h02);
    wait_cmd(50, "R6");
    chk(act_period == 1000, "R6", "running load", act_period, 1000);

    // R4 capture A
    repeat (60) @(negedge tmr_clk);
    wr_ctrl(8'h08);
    wait_cmd(50, "R4");
    chk(cap_a != 0, "R4", "cap_a taken", cap_a, 1);

    // R4 both captures in one write
    repeat (40) @(negedge tmr_clk);
    keep = cap_a;
    wr_ctrl(8'h18);
    wait_cmd(50, "R4");
    chk(cap_a == cap_b, "R4", "same clock captures", cap_b, cap_a);
    chk(cap_a != keep, "R4", "cap_a refreshed", cap_a, keep);

    // R5 restart
    while (!(tmr_count >= 100 && tmr_count < 700)) @(negedge tmr_clk);
    wr_ctrl(8'h04);
    wait_cmd(50, "R5");
    chk(tmr_count < 40, "R5", "counter restarted", tmr_count, 0);

    // R7 end-of-cycle load while running, R3 drops during busy
    buf_period = 300; buf_cmp = 7;
    wr_ctrl(8'h01);
    buf_period = 55; buf_cmp = 2;
    keep = cap_a;
    wr_ctrl(8'h08);
    repeat (10) @(negedge bus_clk);
    chk(!cmd_ready, "R7", "held busy", cmd_ready, 0);
    chk(act_period == 1000, "R7", "not yet loaded", act_period, 1000);
    wait_cmd(3000, "R7");
    chk(act_period == 300, "R7", "loaded at cycle end", act_period, 300);
    chk(act_cmp == 7, "R6", "values from acceptance", act_cmp, 7);
    repeat (10) @(negedge bus_clk);
    chk(cap_a == keep, "R3", "dropped capture", cap_a, keep);

    // R10 end-of-cycle disable
    wr_ctrl(8'h80);
    chk(!en_ready, "R10", "en busy", en_ready, 0);
    repeat (8) @(negedge bus_clk);
    if (!en_ready) chk(tmr_enabled, "R10", "runs until cycle end", tmr_enabled, 1);
    wait_en(3000, "R10");
    chk(!tmr_enabled, "R10", "stopped", tmr_enabled, 0);
    chk(tmr_count == 0, "R10", "count at zero", tmr_count, 0);

    // R7 end-of-cycle load on stopped timer is immediate
    buf_period = 20; buf_cmp = 3;
    wr_ctrl(8'h01);
    wait_cmd(30, "R7");
    chk(act_period == 20, "R7", "stopped timer load", act_period, 20);

    // R11 disable during enable handshake is ignored
    wr_en(1'b1);
    wr_ctrl(8'h80);
    wait_en(50, "R11");
    repeat (100) @(negedge bus_clk);
    chk(tmr_enabled, "R11", "disable dropped", tmr_enabled, 1);

    // R2 bits 6 and 5 have no effect
    wr_ctrl(8'h60);
    chk(cmd_ready && en_ready, "R2", "unused bits", {cmd_ready, en_ready}, 3);

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [7:0] d;
      bit was_ready;
      d = 8'($urandom) & 8'h1F;
      if ($urandom_range(0, 9) == 0) d[7] = 1'b1;
      buf_period = CW'($urandom_range(20, 60));
      buf_cmp    = CW'($urandom_range(0, 20));
      exp_p      = buf_period;
      if ($urandom_range(0, 7) == 0) wr_en(1'b1);
      was_ready = cmd_ready;
      wr_ctrl(d);
      if (was_ready && is_immediate_load(d)) begin
        wait_cmd(200, "R6");
        chk(act_period == exp_p, "R6", "random immediate load", act_period, exp_p);
      end
      repeat ($urandom_range(0, 30)) @(negedge bus_clk);
    end
    wait_cmd(3000, "R2");
    wait_en(3000, "R9");
    repeat (10) @(negedge bus_clk);
    finish_run();
  end
endmodule